// File: doc/BRIEF.md
# SPI Burst-Frame Master Engine

This block is an SPI master that performs one register transaction on an addressed peripheral as a single framed burst. A host hands it a request made of a 16-bit register address, a direction bit and a 15-bit byte count. The engine pulls chip select low and sends a four-byte header. The header holds the address, then a byte that merges the direction with the upper length bits, then the lower length bits. The payload follows under the same chip-select assertion.

For a write, payload bytes are pulled from a ready/valid input stream. When that stream runs dry, the engine stalls with SCLK parked low and chip select still asserted. For a read, the engine clocks out filler bytes and delivers each captured byte on a ready/valid output stream. Chip select is released after the last byte, and the engine stays busy for one further idle SCLK period before it accepts the next request.

Top module: `spi_burst_master`

## Requirements
- R1: `cs_n` goes low before the first SCLK edge of a frame and stays low, without a break, until the last data byte has fully completed. Each accepted non-empty request produces exactly one low period, and `sclk` is low whenever `cs_n` is high.
- R2: The first two header bytes on MOSI are the address bits 15:8, then the address bits 7:0.
- R3: The third header byte is {direction, length[14:8]}, where direction 1 means write and 0 means read. The fourth header byte is length[7:0].
- R4: A request of length N moves exactly N data bytes after the header, and N = 1 is a single-byte access.
- R5: SPI mode 0 is used, MSB first. SCLK idles low, MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and each SCLK high phase lasts DIV/2 system clocks (DIV even, at least 2).
- R6: During the read data phase the master sends 0x00 for every byte. It presents the received bytes in order on `rd_data`/`rd_valid` and holds each one stable until `rd_ready` accepts it.
- R7: Write bytes are taken from `wr_data` when `wr_valid` and `wr_ready` are both high, in order. While no byte is offered, SCLK stays low and `cs_n` stays low.
- R8: A request with length 0 is accepted and answered with a one-cycle `err` pulse. `cs_n` is never asserted for it and `busy` stays low.
- R9: `busy` is high from the cycle after a non-empty request is accepted until DIV system clocks after `cs_n` returns high.
- R10: After reset, `cs_n` is 1, `sclk` is 0, `busy`, `rd_valid` and `err` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_addr | input | 16 | Register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 15 | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Engine takes a write byte this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Captured read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Captured read byte |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | One-cycle pulse for a zero-length request |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |

## Verification
The assertions assume a well-behaved host on both sides. Request fields are only meaningful while `req_valid` is high. A read consumer may withhold `rd_ready` for any length of time. MISO is assumed to change only while SCLK is low. The stimulus respects these assumptions: the bench drives every input on the falling system-clock edge, and its peripheral model updates MISO only after it sees SCLK fall or chip select drop. The write stream and the read acceptance are gated by fixed gap patterns, so that the stall of R7 and the hold of R6 both occur inside real frames.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int HDR_BYTES = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_XFER,
    PH_TAIL
  } phase_t;

  // Header byte k of a frame: address high, address low, {dir, len hi}, len low.
  function automatic logic [7:0] hdr_byte(input logic [2:0] k,
                                          input logic [15:0] addr,
                                          input logic dir_wr,
                                          input logic [14:0] len);
    case (k)
      3'd0:    return addr[15:8];
      3'd1:    return addr[7:0];
      3'd2:    return {dir_wr, len[14:8]};
      default: return len[7:0];
    endcase
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF) + 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic       active,
  output logic [7:0] rx_byte
);
  localparam int HALF = DIV / 2;

  logic [7:0] tx_sh;
  logic [2:0] bit_no;
  logic       tick;

  spi_tick_gen #(.HALF(HALF)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (active),
    .tick(tick)
  );

  assign mosi = tx_sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      bit_no  <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      active  <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tx_sh  <= tx_byte;
        bit_no <= '0;
        active <= 1'b1;
        sclk   <= 1'b0;
      end else if (tick) begin
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_no == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            bit_no <= bit_no + 1'b1;
          end
        end
      end
    end
  end

  // R5: a new byte never starts over one still in flight
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);
  // R5: MOSI only moves while SCLK is low
  a_r5_mosi_low_phase: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int AW    = 16,
  parameter int LW    = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [LW-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          err,
  output logic          cs_n,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int TW = $clog2(DIV) + 1;

  phase_t        phase;
  logic [2:0]    hdr_idx;
  logic [LW-1:0] data_cnt;
  logic [LW-1:0] len_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [TW-1:0] tail_cnt;

  logic          sh_start;
  logic [7:0]    sh_tx;
  logic          sh_done;
  logic          sh_active;
  logic [7:0]    sh_rx;
  logic          in_data;

  assign in_data   = (hdr_idx == 3'(HDR_BYTES));
  assign req_ready = (phase == PH_IDLE);
  assign wr_ready  = (phase == PH_ISSUE) && in_data && wr_q;

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = 8'h00;
    if (phase == PH_ISSUE) begin
      if (!in_data) begin
        sh_start = 1'b1;
        sh_tx    = hdr_byte(hdr_idx, addr_q, wr_q, len_q);
      end else if (wr_q) begin
        sh_start = wr_valid;
        sh_tx    = wr_data;
      end else begin
        sh_start = !rd_valid;
      end
    end
  end

  spi_byte_shifter #(.DIV(DIV)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (sh_start),
    .tx_byte(sh_tx),
    .miso   (miso),
    .sclk   (sclk),
    .mosi   (mosi),
    .done   (sh_done),
    .active (sh_active),
    .rx_byte(sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      hdr_idx  <= '0;
      data_cnt <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      tail_cnt <= '0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      err <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          if (req_len == '0) begin
            err <= 1'b1;
          end else begin
            addr_q   <= req_addr;
            wr_q     <= req_write;
            len_q    <= req_len;
            hdr_idx  <= '0;
            data_cnt <= '0;
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            phase    <= PH_ISSUE;
          end
        end
        PH_ISSUE: if (sh_start) phase <= PH_XFER;
        PH_XFER: if (sh_done) begin
          if (!in_data) begin
            hdr_idx <= hdr_idx + 1'b1;
            phase   <= PH_ISSUE;
          end else begin
            if (!wr_q) begin
              rd_data  <= sh_rx;
              rd_valid <= 1'b1;
            end
            data_cnt <= data_cnt + 1'b1;
            if (data_cnt == len_q - 1'b1) begin
              cs_n     <= 1'b1;
              tail_cnt <= '0;
              phase    <= PH_TAIL;
            end else begin
              phase <= PH_ISSUE;
            end
          end
        end
        default: begin
          tail_cnt <= tail_cnt + 1'b1;
          if (tail_cnt == TW'(DIV - 1)) begin
            busy  <= 1'b0;
            phase <= PH_IDLE;
          end
        end
      endcase
    end
  end

  // R1: no SCLK activity outside a chip-select window
  a_r1_sclk_idle_cs_high: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R9: busy covers the whole chip-select window
  a_r9_busy_covers_cs: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
  // R8: an error pulse never comes with chip select
  a_r8_err_no_cs: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n && !busy));
  // R6: an unaccepted read byte stays put
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R7: while waiting for write data the serial clock is parked low
  a_r7_stall_low: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && !wr_valid) |-> (!sclk && !cs_n && !sh_active));
endmodule

// File: tb/spi_burst_master_test.sv
module spi_burst_master_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [14:0] req_len = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic miso = 1'b0;
  logic req_ready, wr_ready, rd_valid, busy, err, cs_n, sclk, mosi;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_burst_master #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .err(err), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] slave_byte(input int i);
    return 8'((i * 29 + 7) ^ (i >> 3));
  endfunction

  // Peripheral model and per-clock reference checks
  logic [7:0] mosi_q[$];
  logic [7:0] rd_got[$];
  logic [7:0] wr_q[$];
  int   cs_falls = 0, err_seen = 0, byte_i = 0, bit_i = 0, hi_cnt = 0, tail_cnt = 0;
  bit   tail_trk = 0, busy_seen = 0, bp_on = 0, gap_on = 0;
  logic [7:0] sh_in;
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_busy = 1'b0;
  int   cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (err) err_seen++;
      if (busy) busy_seen = 1;
      chk(!(cs_n && sclk), "R1 sclk idle while cs high", sclk, 0);
      chk(!(wr_ready && !wr_valid && sclk), "R7 sclk parked during stall", sclk, 0);
      if (prev_cs && !cs_n) begin
        cs_falls++; byte_i = 0; bit_i = 0;
        miso = slave_byte(0)[7];
      end
      if (!cs_n && !prev_sclk && sclk) begin
        sh_in = {sh_in[6:0], mosi};
        bit_i++;
        if (bit_i == 8) begin mosi_q.push_back(sh_in); byte_i++; bit_i = 0; end
      end
      if (sclk) hi_cnt++;
      if (prev_sclk && !sclk) begin
        chk(hi_cnt == DIV/2, "R5 sclk high phase", hi_cnt, DIV/2);
        hi_cnt = 0;
        miso = slave_byte(byte_i)[7 - bit_i];
      end
      if (!prev_cs && cs_n) begin tail_trk = 1; tail_cnt = 0; end
      if (tail_trk && cs_n && busy) tail_cnt++;
      if (tail_trk && prev_busy && !busy) begin
        chk(tail_cnt == DIV, "R9 busy tail after cs release", tail_cnt, DIV);
        tail_trk = 0;
      end
      // read consumer with optional backpressure
      rd_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
      if (rd_valid && rd_ready) rd_got.push_back(rd_data);
      // write producer with optional gaps
      wr_valid = (wr_q.size() > 0) && (!gap_on || (cyc % 5 < 2));
      wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
      if (wr_valid && wr_ready) void'(wr_q.pop_front());
    end
    prev_sclk = sclk; prev_cs = cs_n; prev_busy = busy;
  end

  task automatic run_txn(input logic [15:0] a, input bit w, input int n,
                         input bit gaps, input bit bp);
    logic [7:0] exp_m[$];
    int f0;
    exp_m = {};
    mosi_q = {}; rd_got = {};
    gap_on = gaps; bp_on = bp;
    exp_m.push_back(a[15:8]); exp_m.push_back(a[7:0]);
    exp_m.push_back({w, 7'(n >> 8)}); exp_m.push_back(8'(n));
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = w ? 8'(i * 13 + 3) : 8'h00;
      if (w) wr_q.push_back(d);
      exp_m.push_back(d);
    end
    f0 = cs_falls;
    req_addr = a; req_write = w; req_len = 15'(n); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R9 busy after accept", busy, 1);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cs_falls - f0 == 1, "R1 single cs window", cs_falls - f0, 1);
    chk(mosi_q.size() == n + 4, "R4 byte count on wire", mosi_q.size(), n + 4);
    for (int i = 0; i < mosi_q.size() && i < exp_m.size(); i++) begin
      if (i < 2)      chk(mosi_q[i] == exp_m[i], "R2 address byte", mosi_q[i], exp_m[i]);
      else if (i < 4) chk(mosi_q[i] == exp_m[i], "R3 dir/len byte", mosi_q[i], exp_m[i]);
      else            chk(mosi_q[i] == exp_m[i], w ? "R7 write data" : "R6 read filler",
                          mosi_q[i], exp_m[i]);
    end
    if (!w) begin
      chk(rd_got.size() == n, "R6 read byte count", rd_got.size(), n);
      for (int i = 0; i < rd_got.size(); i++)
        chk(rd_got[i] == slave_byte(i + 4), "R6 read data", rd_got[i], slave_byte(i + 4));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e0, f0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R10 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R10 reset sclk", sclk, 0);
    chk(!busy && !rd_valid && !err, "R10 reset flags", {busy, rd_valid, err}, 0);
    chk(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);

    run_txn(16'h1234, 1'b1, 1, 1'b0, 1'b0);   // single-byte write
    run_txn(16'hA0C5, 1'b1, 4, 1'b1, 1'b0);   // burst write with stalls
    run_txn(16'h0009, 1'b0, 1, 1'b0, 1'b0);   // single-byte read
    run_txn(16'h7F01, 1'b0, 6, 1'b0, 1'b1);   // burst read with backpressure
    run_txn(16'hFFFE, 1'b1, 257, 1'b0, 1'b0); // length upper bits in byte 3

    // R8: zero-length request
    e0 = err_seen; f0 = cs_falls; busy_seen = 0;
    req_addr = 16'h5555; req_write = 1'b1; req_len = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(err_seen - e0 == 1, "R8 single err pulse", err_seen - e0, 1);
    chk(cs_falls == f0, "R8 no cs for empty request", cs_falls - f0, 0);
    chk(!busy_seen, "R8 busy stays low", busy_seen, 0);

    run_txn(16'h0102, 1'b0, 2, 1'b0, 1'b0);   // engine still healthy

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule